// File: doc/BRIEF.md
# Capture Metadata and Data Merger

This block sits between two first-word-fall-through queues and a storage writer. One queue holds a wide descriptor per captured packet and the other holds that packet's payload as 64-bit words. The block turns the pair into one 64-bit word stream. For each packet it first writes a single 8-byte descriptor word. It then walks through the packet's payload words and keeps only as many as the runtime capture limit allows.

The packet length travels inside the descriptor. The block uses it to work out how many payload words belong to the packet. It removes every one of those words from the payload queue, including the ones it drops, so that the next descriptor always lines up with its own payload. Payload may be queued long before its descriptor, or the other way round. Back-pressure from the output stalls all activity. A synchronous software reset sends the block back to waiting for a descriptor.

Top module: `capture_merge`

## Requirements
- R1: Both queues are first-word-fall-through: the head word is visible on the dout port while empty is low, and a high read strobe pops it at the clock edge. The block never raises a read strobe while that queue's empty input is high.
- R2: While waiting for a packet, with a descriptor present, out_full low and soft_rst low, the block pops the descriptor and in the same cycle raises out_wr with out_dout equal to descriptor bits [63:0].
- R3: The packet length in bytes is descriptor bits [74:64]. After a descriptor is popped, the block pops exactly ceil(length/8) payload words before it pops the next descriptor, and it waits for late payload words as long as needed.
- R4: Of those payload words, the first ceil(min(length, cap)/8) are written out in arrival order, each in the cycle it is popped. The rest are popped without raising out_wr. For example, length 20 with cap 9 keeps 2 of 3 words.
- R5: The cap is sampled from cap_max in the cycle the descriptor is popped. A cap of 0 yields only the descriptor word, and all payload words of that packet are still popped and discarded.
- R6: A descriptor with length 0 produces only the descriptor word and pops no payload. The next descriptor can then be taken.
- R7: While out_full is high, no read strobe and no out_wr is raised, and the packet position is held.
- R8: While waiting for a descriptor, the block never pops the payload queue, so payload queued ahead of its descriptor stays in place.
- R9: While soft_rst is high, nothing is popped or written. Afterwards the block waits for a descriptor, even if the interrupted packet still had payload words outstanding.
- R10: While rst_n is low and after it is released, with both queues empty, meta_rd, data_rd and out_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| cap_max | input | 11 | Maximum bytes of payload kept per packet |
| meta_empty | input | 1 | Descriptor queue empty |
| meta_rd | output | 1 | Descriptor queue pop |
| meta_dout | input | 75 | Descriptor queue head word |
| data_empty | input | 1 | Payload queue empty |
| data_rd | output | 1 | Payload queue pop |
| data_dout | input | 64 | Payload queue head word |
| out_full | input | 1 | Downstream cannot accept a word |
| out_wr | output | 1 | Output word valid |
| out_dout | output | 64 | Output word |

## Verification
The merge is exercised with several packet shapes:
- a full-length packet under a generous cap,
- a cap that is not a multiple of 8 and so rounds up,
- a zero cap,
- a zero-length descriptor.

Together these separate the descriptor path, the keep count and the discard count. Payload is queued both before and after its descriptor, which shows that payload is not consumed while a descriptor is awaited. Back-pressure is raised before a packet starts and again in the middle of one, to show that nothing moves and the position is kept. A software reset is applied while the block waits for missing payload, and the next packet must then start with its descriptor.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [0:0] {
    ST_WAIT_META = 1'b0,
    ST_PAYLOAD   = 1'b1
  } cm_state_e;
endpackage

// File: rtl/cm_len_calc.sv
module cm_len_calc #(
  parameter int LEN_W   = 11,
  parameter int BYTES_W = 3,
  parameter int WCNT_W  = LEN_W + 1 - BYTES_W
) (
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  cap_len,
  output logic [WCNT_W-1:0] total_words,
  output logic [WCNT_W-1:0] keep_words
);
  localparam logic [LEN_W:0] ROUND = (LEN_W+1)'((1 << BYTES_W) - 1);

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W:0]   total_sum;
  logic [LEN_W:0]   keep_sum;

  // bytes actually kept is the smaller of packet length and cap
  assign eff_len   = (pkt_len < cap_len) ? pkt_len : cap_len;
  assign total_sum = {1'b0, pkt_len} + ROUND;
  assign keep_sum  = {1'b0, eff_len} + ROUND;

  assign total_words = WCNT_W'(total_sum >> BYTES_W);
  assign keep_words  = WCNT_W'(keep_sum >> BYTES_W);
endmodule

// File: rtl/cm_seq.sv
module cm_seq
  import cm_pkg::*;
#(
  parameter int WCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              full_i,
  input  logic              meta_empty_i,
  input  logic              data_empty_i,
  input  logic [WCNT_W-1:0] total_i,
  input  logic [WCNT_W-1:0] keep_i,
  output logic              meta_pop_o,
  output logic              data_pop_o,
  output logic              data_keep_o
);
  cm_state_e         state_q, state_d;
  logic [WCNT_W-1:0] cnt_q, cnt_d;
  logic [WCNT_W-1:0] total_q, total_d;
  logic [WCNT_W-1:0] keep_q, keep_d;
  logic              go;
  logic              upd_en;

  assign go = !full_i && !soft_rst;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    total_d     = total_q;
    keep_d      = keep_q;
    meta_pop_o  = 1'b0;
    data_pop_o  = 1'b0;
    data_keep_o = 1'b0;
    case (state_q)
      ST_WAIT_META: begin
        if (go && !meta_empty_i) begin
          meta_pop_o = 1'b1;
          cnt_d      = '0;
          total_d    = total_i;
          keep_d     = keep_i;
          if (total_i != '0) state_d = ST_PAYLOAD;
        end
      end
      ST_PAYLOAD: begin
        if (go && !data_empty_i) begin
          data_pop_o  = 1'b1;
          data_keep_o = (cnt_q < keep_q);
          if (cnt_q == total_q - 1'b1) begin
            state_d = ST_WAIT_META;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_WAIT_META;
    endcase
    if (soft_rst) begin
      state_d = ST_WAIT_META;
      cnt_d   = '0;
    end
  end

  assign upd_en = meta_pop_o || data_pop_o || soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_META;
      cnt_q   <= '0;
      total_q <= '0;
      keep_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      total_q <= total_d;
      keep_q  <= keep_d;
    end
  end

  a_r9_soft_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state_q == ST_WAIT_META));
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAYLOAD) |-> (cnt_q < total_q));
  a_r6_zero_len_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_pop_o && total_i == '0) |=> (state_q == ST_WAIT_META));
  a_r7_hold_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_i && !soft_rst) |=> ($stable(cnt_q) && $stable(state_q)));
  a_r8_no_data_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_META) |-> !data_pop_o);
endmodule

// File: rtl/cm_out_sel.sv
module cm_out_sel #(
  parameter int DATA_W = 64
) (
  input  logic              meta_pop,
  input  logic              data_pop,
  input  logic              data_keep,
  input  logic [DATA_W-1:0] meta_word,
  input  logic [DATA_W-1:0] data_word,
  output logic              wr,
  output logic [DATA_W-1:0] dout
);
  assign wr   = meta_pop || (data_pop && data_keep);
  assign dout = meta_pop ? meta_word : data_word;
endmodule

// File: rtl/capture_merge.sv
module capture_merge #(
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 11,
  parameter int LEN_LSB = 64,
  parameter int META_W  = LEN_LSB + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [LEN_W-1:0]  cap_max,
  input  logic              meta_empty,
  output logic              meta_rd,
  input  logic [META_W-1:0] meta_dout,
  input  logic              data_empty,
  output logic              data_rd,
  input  logic [DATA_W-1:0] data_dout,
  input  logic              out_full,
  output logic              out_wr,
  output logic [DATA_W-1:0] out_dout
);
  localparam int BYTES_W = $clog2(DATA_W / 8);
  localparam int WCNT_W  = LEN_W + 1 - BYTES_W;

  logic [WCNT_W-1:0] total_w;
  logic [WCNT_W-1:0] keep_w;
  logic              keep_now;

  cm_len_calc #(.LEN_W(LEN_W), .BYTES_W(BYTES_W), .WCNT_W(WCNT_W)) u_len (
    .pkt_len     (meta_dout[LEN_LSB +: LEN_W]),
    .cap_len     (cap_max),
    .total_words (total_w),
    .keep_words  (keep_w)
  );

  cm_seq #(.WCNT_W(WCNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .full_i       (out_full),
    .meta_empty_i (meta_empty),
    .data_empty_i (data_empty),
    .total_i      (total_w),
    .keep_i       (keep_w),
    .meta_pop_o   (meta_rd),
    .data_pop_o   (data_rd),
    .data_keep_o  (keep_now)
  );

  cm_out_sel #(.DATA_W(DATA_W)) u_out (
    .meta_pop  (meta_rd),
    .data_pop  (data_rd),
    .data_keep (keep_now),
    .meta_word (meta_dout[DATA_W-1:0]),
    .data_word (data_dout),
    .wr        (out_wr),
    .dout      (out_dout)
  );

  a_r1_meta_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd |-> !meta_empty);
  a_r1_data_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> !data_empty);
  a_r7_quiet_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> (!meta_rd && !data_rd && !out_wr));
  a_r2_meta_emitted: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd |-> (out_wr && out_dout == meta_dout[DATA_W-1:0]));
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(meta_rd && data_rd));
  a_r9_quiet_on_soft: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!meta_rd && !data_rd && !out_wr));
endmodule

// File: tb/capture_merge_bench.sv
module capture_merge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int LW = 11;
  localparam int MW = 75;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [LW-1:0] cap_max = '0;
  logic          meta_empty = 1'b1;
  logic          meta_rd;
  logic [MW-1:0] meta_dout = '0;
  logic          data_empty = 1'b1;
  logic          data_rd;
  logic [DW-1:0] data_dout = '0;
  logic          out_full = 1'b0;
  logic          out_wr;
  logic [DW-1:0] out_dout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [MW-1:0] mq[$];
  logic [DW-1:0] dq[$];
  logic [DW-1:0] exq[$];
  string         tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_merge u_capture_merge (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cap_max(cap_max),
    .meta_empty(meta_empty), .meta_rd(meta_rd), .meta_dout(meta_dout),
    .data_empty(data_empty), .data_rd(data_rd), .data_dout(data_dout),
    .out_full(out_full), .out_wr(out_wr), .out_dout(out_dout)
  );

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  task automatic refresh();
    meta_empty = (mq.size() == 0);
    meta_dout  = meta_empty ? '0 : mq[0];
    data_empty = (dq.size() == 0);
    data_dout  = data_empty ? '0 : dq[0];
  endtask

  // one cycle: the monitor samples mid-cycle, queue pops apply after the edge
  task automatic tick();
    logic m, d;
    string t;
    logic [DW-1:0] e;
    @(negedge clk);
    cyc++;
    m = meta_rd;
    d = data_rd;
    if (m && mq.size() == 0) check(0, "R1", 64'(m), 0);
    if (d && dq.size() == 0) check(0, "R1", 64'(d), 0);
    if ((m || d || out_wr) && (out_full || soft_rst))
      check(0, out_full ? "R7" : "R9", 64'({m, d, out_wr}), 0);
    if (out_wr) begin
      if (exq.size() == 0) check(0, "R3", out_dout, 0);
      else begin
        e = exq.pop_front();
        t = tq.pop_front();
        check(out_dout == e, t, out_dout, e);
      end
    end
    @(posedge clk);
    #1;
    if (m) void'(mq.pop_front());
    if (d) void'(dq.pop_front());
    refresh();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain();
    int n = 0;
    while ((exq.size() > 0 || dq.size() > 0 || mq.size() > 0) && n < 600) begin
      tick();
      n++;
    end
    ticks(2);
    check(exq.size() == 0, "R3", 64'(exq.size()), 0);
    check(dq.size() == 0, "R3", 64'(dq.size()), 0);
  endtask

  function automatic logic [DW-1:0] dword(int pkt, int idx);
    return {16'hD0D0, 16'(pkt), 32'(idx)};
  endfunction

  // driver: queues a packet and records the words the design must write
  task automatic send(int pkt, int len, int cap, bit data_first, int gap, string req);
    int nw, nk, ef;
    logic [MW-1:0] md;
    nw = (len + 7) / 8;
    ef = (len < cap) ? len : cap;
    nk = (ef + 7) / 8;
    md = {LW'(len), 32'hA5A50000 | 32'(pkt), 32'(len * 3 + 1)};
    cap_max = LW'(cap);
    exq.push_back(md[DW-1:0]);
    tq.push_back("R2");
    for (int i = 0; i < nk; i++) begin
      exq.push_back(dword(pkt, i));
      tq.push_back(req);
    end
    if (data_first) begin
      for (int i = 0; i < nw; i++) dq.push_back(dword(pkt, i));
      refresh();
      ticks(gap);
      check(dq.size() == nw, "R8", 64'(dq.size()), 64'(nw));
      mq.push_back(md);
      refresh();
    end else begin
      mq.push_back(md);
      refresh();
      ticks(gap);
      for (int i = 0; i < nw; i++) dq.push_back(dword(pkt, i));
      refresh();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    refresh();
    repeat (3) @(posedge clk);
    #1;
    // R10: quiet in reset and after release
    check(!meta_rd && !data_rd && !out_wr, "R10", 64'({meta_rd, data_rd, out_wr}), 0);
    rst_n = 1'b1;
    ticks(2);
    check(!meta_rd && !data_rd && !out_wr, "R10", 64'({meta_rd, data_rd, out_wr}), 0);

    // R4 full packet, payload queued ahead of descriptor (R8)
    send(1, 64, 1514, 1, 5, "R4");
    drain();
    // R4 cap rounds up: 20 bytes, cap 9 -> keep 2 of 3
    send(2, 20, 9, 0, 3, "R4");
    drain();
    // R5 zero cap: descriptor only, 4 words discarded
    send(3, 30, 0, 1, 2, "R5");
    drain();
    // R6 zero length followed at once by a normal packet
    send(4, 0, 1514, 0, 0, "R6");
    send(5, 13, 1514, 0, 0, "R6");
    drain();
    // R5 cap sampled at descriptor pop, odd length last word
    send(6, 41, 1514, 0, 2, "R5");
    ticks(2);
    cap_max = 11'd8;
    drain();

    // R7 back-pressure before and during a packet
    out_full = 1'b1;
    send(7, 40, 1514, 0, 0, "R7");
    ticks(4);
    check(mq.size() == 1 && dq.size() == 5, "R7", 64'(mq.size() * 16 + dq.size()), 64'h15);
    out_full = 1'b0;
    ticks(2);
    out_full = 1'b1;
    ticks(3);
    check(dq.size() == 4, "R7", 64'(dq.size()), 4);
    out_full = 1'b0;
    drain();

    // R9 software reset while payload is missing
    send(8, 64, 1514, 0, 0, "R3");
    for (int i = 0; i < 8; i++) void'(dq.pop_back());
    dq.push_back(dword(8, 0));
    dq.push_back(dword(8, 1));
    refresh();
    ticks(8);
    check(exq.size() == 6, "R3", 64'(exq.size()), 6);
    exq.delete();
    tq.delete();
    send(9, 16, 1514, 0, 0, "R9");
    soft_rst = 1'b1;
    ticks(2);
    check(mq.size() == 1 && dq.size() == 2, "R9", 64'(mq.size() * 16 + dq.size()), 64'h12);
    soft_rst = 1'b0;
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule